// File: doc/BRIEF.md
# Stack Mapping Bit Analyzer

This block picks which pair of adjacent physical address bits should steer accesses among four memory stacks, so that the operands of one offloaded code block land in the same stack as often as possible. Software or a controller starts a learning session with a sample length. The block then watches the accesses of that many candidate block instances. The start and end of each instance are marked on dedicated inputs. When the sample is complete the analyzer freezes and reports the winning bit position.

Ten candidate mappings are scored side by side. Candidate j uses address bits 7+j+1 and 7+j as a two-bit stack number, so the candidates range from the pair at the 128-byte line boundary up to the pair at bits 17:16. For each candidate, a four-bit mask records which stacks the current instance has touched. When the instance closes, the number of set mask bits is added to that candidate's saturating total. The candidate with the smallest total wins, because it spreads each instance over the fewest stacks. The caller presents only the address window that the candidates can decode: bit 0 of the window is physical bit 7.

Top module: `stack_map_analyzer`

## Requirements
- R1: While rst_n is low at a clock edge, the analyzer returns to idle with done_o = 0 and best_bit_o = 0.
- R2: A start_i pulse in any state clears every mask, total and instance count, captures sample_len_i, drops done_o and begins learning from the next cycle.
- R3: Candidate j (0 to 9) takes window bits [j+1:j], which are physical bits [8+j:7+j], as the stack number 0 to 3.
- R4: Each candidate counts the distinct stacks reached by one instance. inst_begin_i discards earlier accesses. An access in the same cycle as inst_begin_i belongs to the new instance. An access in the same cycle as inst_end_i belongs to the closing instance.
- R5: At inst_end_i each candidate adds its distinct-stack count to its total, and the total saturates at 2^ACC_W-1 instead of wrapping.
- R6: done_o rises in the cycle after the edge that accepts the sample_len-th inst_end_i. A sample length of 0 behaves as 1.
- R7: While done_o is high, best_bit_o = 7 + the index of the candidate with the lowest total, and ties go to the lowest index. While done_o is low, best_bit_o = 0.
- R8: Outside a learning session (after reset before any start, and after done), every input except start_i is ignored, and done_o and best_bit_o hold.
- R9: An inst_end_i with no access in its instance still counts toward the sample length but adds nothing to any total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new learning session |
| sample_len_i | input | CNT_W | Number of instances to learn from, captured at start |
| inst_begin_i | input | 1 | First-cycle marker of a candidate block instance |
| inst_end_i | input | 1 | Closing marker of a candidate block instance |
| acc_valid_i | input | 1 | An access address is present this cycle |
| line_addr_i | input | NUM_MAPS+1 | Physical address bits 7 upward of the access |
| done_o | output | 1 | Sample complete, result frozen |
| best_bit_o | output | IDX_W | Low bit index of the chosen stack-select pair |

## Verification
The assertions assume that each instance brings at most four distinct stacks into a total. They also assume that inst_end_i outside a session has no effect, and that a start pulse can arrive at any moment, so every property is written to yield to start_i. The stimulus keeps to these assumptions by always opening an instance with a begin marker, closing it with exactly one end marker, and issuing start only as a lone one-cycle pulse. Learning totals are kept by a bench model that decodes the bit pairs itself. The hard-coded cases place the winner at a non-trivial position, on a tie, and behind saturation.

// File: rtl/smba_pkg.sv
// Package: shared constants, state type and the four-bit population count
// used by the stack mapping bit analyzer.
package smba_pkg;

    localparam int STACKS = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEARN = 2'd1,
        ST_DONE  = 2'd2
    } smba_state_t;

    // Number of stacks marked in a touched-stack mask.
    function automatic logic [2:0] pop4(input logic [STACKS-1:0] m);
        return 3'(m[0]) + 3'(m[1]) + 3'(m[2]) + 3'(m[3]);
    endfunction

endpackage

// File: rtl/smba_lane.sv
// Module: one candidate mapping. Keeps the touched-stack mask of the open
// instance and a saturating total of distinct stacks per closed instance.
// Assumes the controller asserts learn_i only during a session; clear_i wins.
module smba_lane
    import smba_pkg::*;
#(
    parameter int ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             learn_i,
    input  logic             begin_i,
    input  logic             end_i,
    input  logic             valid_i,
    input  logic [1:0]       pair_i,
    output logic [ACC_W-1:0] acc_o
);

    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    logic [STACKS-1:0] mask_q;
    logic [STACKS-1:0] mask_nxt;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W:0]    sum;

    // Mask for this cycle: restart on begin, add the decoded stack of an access.
    always_comb begin
        mask_nxt = begin_i ? '0 : mask_q;
        if (valid_i) mask_nxt = mask_nxt | (STACKS'(1) << pair_i);
    end

    assign sum = {1'b0, acc_q} + (ACC_W+1)'(pop4(mask_nxt));

    // Mask and total registers, cleared on reset and on session start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            mask_q <= '0;
            acc_q  <= '0;
        end else if (learn_i) begin
            mask_q <= end_i ? '0 : mask_nxt;
            if (end_i) acc_q <= sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
        end
    end

    assign acc_o = acc_q;

    // R5: a total never falls within a session
    p_acc_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i) |=> (acc_q >= $past(acc_q)));

    // R5: a saturated total stays saturated
    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == ACC_MAX && !clear_i) |=> (acc_q == ACC_MAX));

    // R4: one instance adds at most four stacks
    p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i) |=> ({1'b0, acc_q} <= {1'b0, $past(acc_q)} + (ACC_W+1)'(4)));

    // R9: an instance without accesses leaves the total unchanged
    p_empty_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (learn_i && end_i && !valid_i && !clear_i && (begin_i || mask_q == '0))
        |=> $stable(acc_q));

    // R8: outside a session nothing moves
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!learn_i && !clear_i) |=> ($stable(acc_q) && $stable(mask_q)));

endmodule

// File: rtl/smba_argmin.sv
// Module: combinational search for the candidate with the smallest total.
// Scans upward and replaces only on a strictly smaller value, so ties keep
// the lowest index. Assumes NUM_MAPS >= 2.
module smba_argmin #(
    parameter int NUM_MAPS = 10,
    parameter int ACC_W    = 20,
    parameter int SEL_W    = $clog2(NUM_MAPS)
) (
    input  logic [NUM_MAPS-1:0][ACC_W-1:0] acc_i,
    output logic [SEL_W-1:0]               sel_o
);

    logic [ACC_W-1:0] best;

    // Linear scan for the lowest total, ties resolved toward index 0.
    always_comb begin
        best  = acc_i[0];
        sel_o = '0;
        for (int i = 1; i < NUM_MAPS; i++) begin
            if (acc_i[i] < best) begin
                best  = acc_i[i];
                sel_o = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/smba_ctrl.sv
// Module: session sequencer. Captures the sample length on start, counts
// closed instances and freezes the analyzer once the sample is complete.
// Assumes start_i is a one-cycle pulse; a zero length acts as one.
module smba_ctrl
    import smba_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             end_i,
    output logic             learn_o,
    output logic             done_o
);

    smba_state_t      st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W:0]   len_eff;
    logic [CNT_W:0]   cnt_inc;

    assign len_eff = (len_q == '0) ? (CNT_W+1)'(1) : {1'b0, len_q};
    assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);

    // Session state, instance counter and captured length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            len_q <= '0;
        end else if (start_i) begin
            st_q  <= ST_LEARN;
            cnt_q <= '0;
            len_q <= len_i;
        end else if (st_q == ST_LEARN && end_i) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
            if (cnt_inc >= len_eff) st_q <= ST_DONE;
        end
    end

    assign learn_o = (st_q == ST_LEARN);
    assign done_o  = (st_q == ST_DONE);

    // R8: done persists until the next start
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R2: a start always reopens learning
    p_start_learn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (learn_o && !done_o));

    // R6: the count never reaches the length while still learning
    p_count_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
        learn_o |-> ({1'b0, cnt_q} < len_eff));

    // R6: done rises only after an accepted end marker
    p_done_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(end_i && learn_o));

endmodule

// File: rtl/stack_map_analyzer.sv
// Module: top of the stack mapping bit analyzer. One lane per candidate bit
// pair, a sequencer, and a lowest-total search that drives the result.
// Assumes line_addr_i bit 0 is physical address bit BIT_BASE.
module stack_map_analyzer
    import smba_pkg::*;
#(
    parameter int NUM_MAPS = 10,
    parameter int BIT_BASE = 7,
    parameter int ACC_W    = 20,
    parameter int CNT_W    = 16,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CNT_W-1:0]    sample_len_i,
    input  logic                inst_begin_i,
    input  logic                inst_end_i,
    input  logic                acc_valid_i,
    input  logic [NUM_MAPS:0]   line_addr_i,
    output logic                done_o,
    output logic [IDX_W-1:0]    best_bit_o
);

    localparam int SEL_W = $clog2(NUM_MAPS);

    logic                          learn;
    logic                          done;
    logic [NUM_MAPS-1:0][ACC_W-1:0] acc_all;
    logic [SEL_W-1:0]              sel;

    smba_ctrl #(.CNT_W(CNT_W)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .len_i   (sample_len_i),
        .end_i   (inst_end_i),
        .learn_o (learn),
        .done_o  (done)
    );

    // One scoring lane per candidate pair of adjacent address bits.
    for (genvar g = 0; g < NUM_MAPS; g++) begin : g_lane
        smba_lane #(.ACC_W(ACC_W)) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (start_i),
            .learn_i (learn),
            .begin_i (inst_begin_i),
            .end_i   (inst_end_i),
            .valid_i (acc_valid_i),
            .pair_i  (line_addr_i[g +: 2]),
            .acc_o   (acc_all[g])
        );

        // R7: the chosen candidate has no larger total than this one
        p_min_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (acc_all[sel] <= acc_all[g]));

        // R7: every lower-index candidate is strictly worse
        p_tie_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (done && (int'(sel) > g)) |-> (acc_all[g] > acc_all[sel]));
    end

    smba_argmin #(.NUM_MAPS(NUM_MAPS), .ACC_W(ACC_W), .SEL_W(SEL_W)) i_argmin (
        .acc_i (acc_all),
        .sel_o (sel)
    );

    // Result is the low bit of the winning pair, zero while not frozen.
    assign best_bit_o = done ? IDX_W'(BIT_BASE + int'(sel)) : '0;
    assign done_o     = done;

    // R8: the reported bit is stable while frozen
    p_best_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_i) |=> $stable(best_bit_o));

endmodule

// File: tb/test_stack_map_analyzer.sv
// Bench: walks a table of instances against a bit-pair model, then directed
// tests for reset, ties, empty instances, marker overlap, restart and saturation.
module test_stack_map_analyzer;

    localparam int NM    = 10;
    localparam int ACC_W = 6;
    localparam int AMAX  = (1 << ACC_W) - 1;

    typedef struct packed {
        logic [2:0]        n;
        logic [3:0][31:0]  a;
        logic              exp_done;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{3'd2, {32'h0, 32'h0, 32'h0010_3000, 32'h0010_0000}, 1'b0},
        '{3'd2, {32'h0, 32'h0, 32'h0010_3400, 32'h0010_0400}, 1'b0},
        '{3'd3, {32'h0, 32'h0010_6800, 32'h0010_3800, 32'h0010_0800}, 1'b0},
        '{3'd0, {32'h0, 32'h0, 32'h0, 32'h0}, 1'b0},
        '{3'd4, {32'h0010_1080, 32'h0010_7000, 32'h0010_4000, 32'h0010_1000}, 1'b0},
        '{3'd1, {32'h0, 32'h0, 32'h0, 32'h0010_2000}, 1'b1}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start_i = 0;
    logic [15:0] sample_len_i = '0;
    logic        inst_begin_i = 0;
    logic        inst_end_i = 0;
    logic        acc_valid_i = 0;
    logic [31:0] addr = '0;
    logic        done_o;
    logic [4:0]  best_bit_o;

    int checks = 0;
    int fails  = 0;
    int macc [NM];

    always #10 clk = ~clk;

    stack_map_analyzer #(.ACC_W(ACC_W)) i_stack_map_analyzer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .sample_len_i (sample_len_i),
        .inst_begin_i (inst_begin_i),
        .inst_end_i   (inst_end_i),
        .acc_valid_i  (acc_valid_i),
        .line_addr_i  (addr[17:7]),
        .done_o       (done_o),
        .best_bit_o   (best_bit_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One cycle with the given marker and access inputs.
    task automatic cyc(input bit b, input bit e, input bit v, input logic [31:0] a);
        inst_begin_i = b; inst_end_i = e; acc_valid_i = v; addr = a;
        @(negedge clk);
        inst_begin_i = 0; inst_end_i = 0; acc_valid_i = 0; addr = '0;
    endtask

    task automatic start_sess(input int len);
        start_i = 1; sample_len_i = 16'(len);
        @(negedge clk);
        start_i = 0;
        for (int j = 0; j < NM; j++) macc[j] = 0;
    endtask

    // Begin cycle, n access cycles, end cycle; optionally update the model.
    task automatic inst(input int n, input logic [3:0][31:0] a, input bit upd);
        cyc(1, 0, 0, '0);
        for (int k = 0; k < n; k++) cyc(0, 0, 1, a[k]);
        cyc(0, 1, 0, '0);
        if (upd) begin
            for (int j = 0; j < NM; j++) begin
                logic [3:0] m = '0;
                for (int k = 0; k < n; k++) m[a[k][7+j +: 2]] = 1'b1;
                macc[j] = macc[j] + $countones(m);
                if (macc[j] > AMAX) macc[j] = AMAX;
            end
        end
    endtask

    function automatic int model_best();
        int b = 0;
        for (int j = 1; j < NM; j++) if (macc[j] < macc[b]) b = j;
        return 7 + b;
    endfunction

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        report();
    end

    initial begin
        logic [3:0][31:0] lines;
        lines = {32'h180, 32'h100, 32'h80, 32'h0};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done_o == 0, "R1 done", int'(done_o), 0);
        chk(best_bit_o == 0, "R1 best", int'(best_bit_o), 0);
        rst_n = 1;
        @(negedge clk);

        // R8: activity before any start is ignored
        inst(4, lines, 0);
        chk(done_o == 0, "R8 idle done", int'(done_o), 0);
        start_sess(1);
        inst(1, {32'h0, 32'h0, 32'h0, 32'h0}, 1);
        chk(best_bit_o == 7, "R8 idle ignored", int'(best_bit_o), 7);

        // R3 R4 R5 R6 R7: table walk against the model
        start_sess(6);
        for (int r = 0; r < 6; r++) begin
            inst(int'(TBL[r].n), TBL[r].a, 1);
            chk(done_o == TBL[r].exp_done, "R6 done timing", int'(done_o), int'(TBL[r].exp_done));
        end
        chk(best_bit_o == 5'(model_best()), "R3 table best", int'(best_bit_o), model_best());

        // R7: consecutive lines; bits 9 and up tie, lowest wins
        start_sess(2);
        inst(4, lines, 1);
        inst(4, lines, 1);
        chk(best_bit_o == 9, "R7 tie low", int'(best_bit_o), 9);
        chk(best_bit_o == 5'(model_best()), "R4 lines model", int'(best_bit_o), model_best());

        // R2: restart clears old totals
        start_sess(1);
        chk(done_o == 0, "R2 done cleared", int'(done_o), 0);
        inst(2, {32'h0, 32'h0, 32'h8000, 32'h0}, 1);
        chk(best_bit_o == 7, "R2 restart", int'(best_bit_o), 7);

        // R9: empty instances count but add nothing
        start_sess(3);
        inst(0, '0, 1);
        inst(0, '0, 1);
        chk(done_o == 0, "R9 count not done", int'(done_o), 0);
        inst(2, {32'h0, 32'h0, 32'h80, 32'h0}, 1);
        chk(done_o == 1, "R9 count done", int'(done_o), 1);
        chk(best_bit_o == 8, "R9 best", int'(best_bit_o), 8);

        // R6: zero length acts as one
        start_sess(0);
        inst(2, {32'h0, 32'h0, 32'h100, 32'h0}, 1);
        chk(done_o == 1, "R6 zero len done", int'(done_o), 1);
        chk(best_bit_o == 9, "R6 zero len best", int'(best_bit_o), 9);

        // R8: inputs after done are ignored
        inst(4, {32'h600, 32'h400, 32'h200, 32'h0}, 0);
        chk(done_o == 1, "R8 frozen done", int'(done_o), 1);
        chk(best_bit_o == 9, "R8 frozen best", int'(best_bit_o), 9);

        // R4: access with begin starts a fresh mask
        start_sess(1);
        cyc(0, 0, 1, 32'h80);
        cyc(1, 0, 1, 32'h0);
        cyc(0, 1, 0, '0);
        chk(best_bit_o == 7, "R4 begin overlap", int'(best_bit_o), 7);

        // R4: access with end belongs to the closing instance
        start_sess(1);
        cyc(1, 0, 0, '0);
        cyc(0, 0, 1, 32'h0);
        cyc(0, 1, 1, 32'h80);
        chk(best_bit_o == 8, "R4 end overlap", int'(best_bit_o), 8);

        // R5: totals saturate so all tie and bit 7 wins
        start_sess(70);
        for (int r = 0; r < 70; r++) inst(4, lines, 0);
        chk(done_o == 1, "R5 sat done", int'(done_o), 1);
        chk(best_bit_o == 7, "R5 saturation", int'(best_bit_o), 7);

        // R1: reset mid-result
        rst_n = 0;
        @(negedge clk);
        chk(done_o == 0 && best_bit_o == 0, "R1 late reset", int'(best_bit_o), 0);
        rst_n = 1;
        @(negedge clk);
        report();
    end

endmodule